// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides when an outside bus master may take over the local system bus. A device that wants the bus raises a hold request. The arbiter samples that request on every rising clock edge and watches the phase reported by the local bus-cycle sequencer. It never cuts a bus cycle short. It grants the bus only at a cycle boundary, which is an idle clock or the last clock of a cycle. On a grant it raises the hold acknowledge and tells the sequencer to float its address, data, status and strobe outputs.

For as long as the request stays high, the arbiter keeps the bus handed over and blocks any new local cycle. Once the request is withdrawn, it drops the acknowledge one clock after it samples the low level. In that same clock the bus returns to local ownership, and a local cycle that was waiting may begin with its first state.

The sequencer reports its phase as a 3-bit code: 0 idle, 1 first state, 2 second state, 3 third state, 4 wait state, 5 last state. The arbiter answers with a start permission for the next local cycle.

Top module: `hold_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `hlda` and `bus_float` are cleared after that edge, so the bus is owned locally.
- R2: `hold_req` is captured at each rising edge. A high level captured at edge k, with `bus_phase` at 0 (idle) or 5 (last state) at edge k+1, sets `hlda` after edge k+1.
- R3: `hlda` never rises at an edge where `bus_phase` is 1, 2, 3 or 4 (inside a cycle). A request made during a cycle is granted at the boundary that ends the cycle.
- R4: `bus_float` is high in exactly the clocks where `hlda` is high.
- R5: Once `hlda` is high, it stays high while each captured `hold_req` level is high, whatever the phase.
- R6: A low `hold_req` captured at edge k, while `hlda` is high, clears `hlda` after edge k+1.
- R7: `cyc_start` is high only when `cyc_req` is high, `bus_phase` is 0 or 5, `hlda` is low and the last captured `hold_req` is low. It is therefore low throughout a hold.
- R8: A request withdrawn before any boundary has no effect. `hlda` stays low and the next boundary lets a waiting local cycle start.
- R9: A local request that waits through a hold gets `cyc_start` in the first clock after `hlda` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req | input | 1 | Bus request from the outside master |
| bus_phase | input | 3 | Sequencer phase: 0 idle, 1..3 T-states, 4 wait, 5 last |
| cyc_req | input | 1 | Local cycle waiting to start |
| hlda | output | 1 | Hold acknowledge to the outside master |
| bus_float | output | 1 | Sequencer outputs to high impedance |
| cyc_start | output | 1 | Permission for the sequencer to enter its first state |

## Verification
The request is raised in an idle clock, which tests the two-clock grant latency. It is raised early in a cycle that includes a wait state, which shows that the grant waits for the last state and not the first boundary-like phase. It is also pulsed and dropped inside a cycle, which separates a latched request from a sampled one. Local requests are held high across a whole hold, so that a leak of `cyc_start` during the hold is told apart from the correct start in the first clock after release.

// File: rtl/hold_arb_pkg.sv
// Package: shared phase encoding and boundary decode for the hold arbiter.
// Assumes the sequencer reports one phase per clock in the encoding below.
package hold_arb_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } bus_phase_e;

    typedef enum logic {
        OWN_LOCAL = 1'b0,
        OWN_REMOTE = 1'b1
    } owner_e;

    // True when the bus may change hands after this clock.
    function automatic logic at_boundary(input logic [PHASE_W-1:0] ph);
        return (ph == PH_IDLE) || (ph == PH_T4);
    endfunction

endpackage

// File: rtl/hold_arb_sampler.sv
// Module: hold_arb_sampler
// Captures the external hold request on rising edges through STAGES
// flops. Assumes STAGES >= 1; reset clears every stage.
module hold_arb_sampler #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    output logic req_seen
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage: take the raw request.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= req_in;
                end
            end else begin : g_next
                // Later stages: shift the captured level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign req_seen = chain_q[STAGES-1];
endmodule

// File: rtl/hold_arb_owner.sv
// Module: hold_arb_owner
// Two-state ownership machine. It hands the bus out only at a cycle
// boundary and takes it back one clock after the captured request falls.
// Assumes the sequencer phase is valid in every clock out of reset.
module hold_arb_owner
    import hold_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_seen,
    input  logic [PHASE_W-1:0] phase,
    output logic               granted,
    output logic               float_en
);
    owner_e state_q, state_d;

    // Next owner: grant at a boundary, keep while requested.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_LOCAL:  if (req_seen && at_boundary(phase)) state_d = OWN_REMOTE;
            OWN_REMOTE: if (!req_seen) state_d = OWN_LOCAL;
            default:    state_d = OWN_LOCAL;
        endcase
    end

    // Owner register with synchronous reset to local ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_LOCAL;
        else        state_q <= state_d;
    end

    // Registered float enable, set and cleared with the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) float_en <= 1'b0;
        else        float_en <= (state_d == OWN_REMOTE);
    end

    assign granted = (state_q == OWN_REMOTE);
endmodule

// File: rtl/hold_arb_gate.sv
// Module: hold_arb_gate
// Lets a waiting local cycle start only at a boundary, and only while
// the bus is neither handed over nor about to be.
module hold_arb_gate
    import hold_arb_pkg::*;
(
    input  logic               cyc_req,
    input  logic [PHASE_W-1:0] phase,
    input  logic               granted,
    input  logic               req_seen,
    output logic               start_ok
);
    // Start permission from the request, boundary and ownership.
    always_comb begin
        start_ok = cyc_req && at_boundary(phase) && !granted && !req_seen;
    end
endmodule

// File: rtl/hold_bus_arbiter.sv
// Module: hold_bus_arbiter (top)
// Hold request / acknowledge arbiter between an outside bus master and
// the local bus-cycle sequencer. Assumes a synchronous active-low reset
// and a hold request that is stable around rising edges.
module hold_bus_arbiter #(
    parameter int SYNC_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_req,
    input  logic [2:0] bus_phase,
    input  logic       cyc_req,
    output logic       hlda,
    output logic       bus_float,
    output logic       cyc_start
);
    import hold_arb_pkg::*;

    logic req_seen;
    logic granted;

    hold_arb_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (hold_req),
        .req_seen (req_seen)
    );

    hold_arb_owner u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_seen (req_seen),
        .phase    (bus_phase),
        .granted  (granted),
        .float_en (bus_float)
    );

    hold_arb_gate u_gate (
        .cyc_req  (cyc_req),
        .phase    (bus_phase),
        .granted  (granted),
        .req_seen (req_seen),
        .start_ok (cyc_start)
    );

    assign hlda = granted;
endmodule

// File: rtl/hold_bus_arbiter_chk.sv
// Module: hold_bus_arbiter_chk
// Port-level checker for the hold arbiter, bound to the top module.
module hold_bus_arbiter_chk #(
    parameter int SYNC_STAGES = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_req,
    input logic [2:0] bus_phase,
    input logic       cyc_req,
    input logic       hlda,
    input logic       bus_float,
    input logic       cyc_start
);
    logic edge_phase;
    assign edge_phase = (bus_phase == 3'd0) || (bus_phase == 3'd5);

    // R1: reset leaves the bus locally owned.
    a_r1_reset_local: assert property (@(posedge clk)
        !rst_n |=> (!hlda && !bus_float));

    // R3: no grant inside a cycle.
    a_r3_no_mid_cycle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!hlda && !edge_phase) |=> !hlda);

    // R4: float follows acknowledge.
    a_r4_float_with_hlda: assert property (@(posedge clk) disable iff (!rst_n)
        bus_float == hlda);

    // R7: no local start while the bus is handed over.
    a_r7_no_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !cyc_start);

    generate
        if (SYNC_STAGES == 1) begin : g_single
            // R2: captured request at a boundary grants the bus.
            a_r2_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !hlda && $past(hold_req) && edge_phase) |=> hlda);
            // R5: hold kept while the captured request stays high.
            a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && hlda && $past(hold_req)) |=> hlda);
            // R6: captured low request releases the bus.
            a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && hlda && !$past(hold_req)) |=> !hlda);
        end
    endgenerate
endmodule

bind hold_bus_arbiter hold_bus_arbiter_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (hold_req),
    .bus_phase (bus_phase),
    .cyc_req   (cyc_req),
    .hlda      (hlda),
    .bus_float (bus_float),
    .cyc_start (cyc_start)
);

// File: tb/test_hold_bus_arbiter.sv
// Bench for hold_bus_arbiter: a vector table walked once, then directed
// reset checks. Inputs change on falling edges; cyc_start is read before
// the rising edge and hlda / bus_float after it.
module test_hold_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_req = 1'b0;
    logic [2:0] bus_phase = 3'd0;
    logic       cyc_req = 1'b0;
    logic       hlda, bus_float, cyc_start;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hold_bus_arbiter i_hold_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .bus_phase(bus_phase),
        .cyc_req(cyc_req), .hlda(hlda), .bus_float(bus_float), .cyc_start(cyc_start)
    );

    // Vector: {hold, phase[2:0], req, exp_start, exp_hlda_after_edge}
    localparam int NV = 23;
    localparam logic [6:0] VEC [NV] = '{
        {1'b0, 3'd0, 1'b1, 1'b1, 1'b0},  // R7 idle start
        {1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0},  // R3 request mid cycle
        {1'b1, 3'd3, 1'b0, 1'b0, 1'b0},  // R3
        {1'b1, 3'd4, 1'b0, 1'b0, 1'b0},  // R3 wait state
        {1'b1, 3'd5, 1'b1, 1'b0, 1'b1},  // R2 grant at last state, R7 blocked
        {1'b1, 3'd0, 1'b1, 1'b0, 1'b1},  // R5
        {1'b1, 3'd0, 1'b1, 1'b0, 1'b1},  // R5
        {1'b0, 3'd0, 1'b1, 1'b0, 1'b1},  // R6 low captured here
        {1'b0, 3'd0, 1'b1, 1'b0, 1'b0},  // R6 released after this edge
        {1'b0, 3'd0, 1'b1, 1'b1, 1'b0},  // R9 waiting cycle starts
        {1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0},  // R8 short request
        {1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
        {1'b0, 3'd3, 1'b0, 1'b0, 1'b0},  // R8 withdrawn
        {1'b0, 3'd5, 1'b1, 1'b1, 1'b0},  // R8 no grant, start allowed
        {1'b1, 3'd1, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd2, 1'b1, 1'b0, 1'b0},  // R7 req mid cycle ignored
        {1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd5, 1'b1, 1'b0, 1'b1},  // R2
        {1'b0, 3'd0, 1'b1, 1'b0, 1'b1},  // R5 still held this edge
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0},  // R6
        {1'b0, 3'd0, 1'b1, 1'b1, 1'b0}   // R9
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 hlda after reset", hlda, 1'b0);
        check("R1 bus_float after reset", bus_float, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            hold_req  = VEC[i][6];
            bus_phase = VEC[i][5:3];
            cyc_req   = VEC[i][2];
            #2;
            check($sformatf("R7 cyc_start vec %0d", i), cyc_start, VEC[i][1]);
            @(posedge clk);
            #2;
            check($sformatf("R2/R3/R5/R6 hlda vec %0d", i), hlda, VEC[i][0]);
            check($sformatf("R4 bus_float vec %0d", i), bus_float, VEC[i][0]);
        end

        // R1: reset during a hold returns the bus at once.
        @(negedge clk);
        hold_req = 1'b1; bus_phase = 3'd0; cyc_req = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R2 idle grant two clocks", hlda, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1 reset clears hlda in hold", hlda, 1'b0);
        check("R1 reset clears bus_float in hold", bus_float, 1'b0);
        @(negedge clk);
        hold_req = 1'b0; cyc_req = 1'b1;
        rst_n = 1'b1;
        #2;
        check("R7 start after reset", cyc_start, 1'b1);

        finish_run();
    end
endmodule